// File: doc/BRIEF.md
# Programmable Handshake Parallel Port

This block gives a processor one 8-bit peripheral port. The port has an output data register and an input data register, and every transfer in either direction passes through one of them. A ready/strobe handshake moves whole bytes between the registers and the peripheral. A two-bit mode selects one of four behaviours: byte output, byte input, bidirectional, or bit control. In bit control mode each line is set as input or output on its own, and an interrupt fires when the unmasked lines meet a programmed condition.

The processor side is a one-cycle register interface. `cpu_ctl` chooses between the data register and the control register. Control words are told apart by their low bits. They set the mode, the interrupt vector, the interrupt enable and the bit-control match rule. When bit control mode is selected, the next two control writes are taken as the direction byte and then the mask byte. On the peripheral side the block drives output data, a per-bit enable for an external tristate buffer, and a ready line. It receives input data and an active-low strobe. Both are passed through a two-flop synchroniser. The interrupt request is a level that stays high until `irq_ack` is pulsed. The stored vector is always visible on `vec` for an external priority chain.

Top module: `hsport`

## Requirements
- R1: After reset, `per_rdy` = 0, `irq` = 0, `per_oe` = 0x00 (the reset mode is byte input) and `vec` = 0x00.
- R2: A control write whose bit 0 is 0 stores the whole byte as the interrupt vector, and `vec` shows it from the next cycle. This does not apply while a direction or mask byte is expected.
- R3: A control write with bits[3:0] = 1111 selects the mode from bits[7:6]: 00 = byte output, 01 = byte input, 10 = bidirectional, 11 = bit control. The same write clears ready, the interrupt enable and any pending request.
- R4: In byte output mode, `per_oe` = 0xFF. A data write drives the byte on `per_dout` and sets `per_rdy` high from the next cycle.
- R5: In byte output mode, a strobe pulse (low, then high) while ready is high drops ready after the rising edge and, if interrupts are enabled, raises `irq`. A strobe while ready is low changes nothing.
- R6: In byte input mode, `per_oe` = 0x00 and a data read raises ready. When the strobe falls while ready is high, the port data is latched and ready drops. The rising edge then requests an interrupt. While ready is low, a strobe neither changes the input register nor requests an interrupt. A data read returns the input register.
- R7: In bidirectional mode, ready means the output register is full. A data write sets ready. `per_oe` = 0xFF only while ready is high and the synchronised strobe is low. The strobe's rising edge then drops ready and requests an interrupt. A strobe while ready is low latches the port data into the input register and requests an interrupt.
- R8: After a bit-control mode word, the next control write is the direction byte (bit = 1 means input) and the one after it is the mask byte. Neither is decoded as a command. `per_oe` is the inverse of the direction byte and ready stays low. A data read returns the synchronised port data on input bits and the output register on output bits.
- R9: A control write with bits[3:0] = 0111 sets the enable from bit 7, the match rule from bit 6 (1 = all unmasked bits, 0 = any unmasked bit) and the active level from bit 5 (1 = high). In bit control mode, a change of the match result from false to true raises `irq` while enabled.
- R10: A control write with bits[3:0] = 0011 sets the interrupt enable from bit 7. Writing 0 also withdraws a pending request.
- R11: Pulsing `irq_ack` drops `irq` in the next cycle. Handshake events that complete while interrupts are disabled are not remembered.
- R12: In bit control mode, a line whose mask bit is 1 has no effect on the match and can never trigger an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | One-cycle write strobe |
| cpu_rd | input | 1 | One-cycle read strobe |
| cpu_ctl | input | 1 | 1 = control register, 0 = data register |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data (data register; 0 on control reads) |
| per_din | input | 8 | Port data from the peripheral |
| per_dout | output | 8 | Port data to the peripheral |
| per_oe | output | 8 | Per-bit enable for the external tristate buffer |
| per_rdy | output | 1 | Ready to the peripheral |
| per_stb_n | input | 1 | Active-low strobe from the peripheral |
| irq | output | 1 | Interrupt request level |
| irq_ack | input | 1 | Acknowledge pulse that clears the request |
| vec | output | 8 | Stored interrupt vector |

## Verification
Register-side results appear one cycle after the access: the vector, ready after a data write or read, and the state after a mode word. The bench drives every access for a single cycle between falling edges and samples at the following falling edge. Strobe and port-data changes go through two synchroniser flops and one edge register, so their effects arrive on the third clock edge. The bench therefore holds each strobe level for five cycles and lets port data settle for five cycles before it compares ready, `irq`, `per_oe` or read data. In the random bit-control runs, the expected interrupt is formed from the false-to-true change of a bench-side match function evaluated before and after each settled input change.

// File: rtl/hsport.sv
module hsport #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_wr,
  input  logic          cpu_rd,
  input  logic          cpu_ctl,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic [DW-1:0] per_din,
  output logic [DW-1:0] per_dout,
  output logic [DW-1:0] per_oe,
  output logic          per_rdy,
  input  logic          per_stb_n,
  output logic          irq,
  input  logic          irq_ack,
  output logic [DW-1:0] vec
);
  localparam logic [1:0] M_OUT = 2'd0;
  localparam logic [1:0] M_IN  = 2'd1;
  localparam logic [1:0] M_BI  = 2'd2;
  localparam logic [1:0] M_BIT = 2'd3;
  localparam logic [1:0] S_IDLE = 2'd0;
  localparam logic [1:0] S_DIR  = 2'd1;
  localparam logic [1:0] S_MASK = 2'd2;

  logic [1:0]    mode, seq, stb_s;
  logic [DW-1:0] outreg, inreg, dir, mask, din_s1, din_s2, line, hit;
  logic          rdy, ie, andm, lvl, pend, armed, match, match_q, stb_q;

  wire fall = (mode != M_BIT) && stb_q && !stb_s[1];
  wire rise = (mode != M_BIT) && !stb_q && stb_s[1];
  wire dwr  = cpu_wr && !cpu_ctl;
  wire cwr  = cpu_wr && cpu_ctl;
  wire drd  = cpu_rd && !cpu_ctl;

  assign line  = (din_s2 & dir) | (outreg & ~dir);
  assign hit   = lvl ? line : ~line;
  assign match = (mode == M_BIT) && (seq == S_IDLE) &&
                 (andm ? ((&(hit | mask)) && (mask != '1)) : (|(hit & ~mask)));

  assign per_dout = outreg;
  assign per_rdy  = rdy;
  assign irq      = pend;

  always_comb begin
    case (mode)
      M_OUT:   per_oe = '1;
      M_IN:    per_oe = '0;
      M_BI:    per_oe = (rdy && !stb_s[1]) ? '1 : '0;
      default: per_oe = ~dir;
    endcase
  end

  always_comb begin
    if (cpu_ctl)             cpu_rdata = '0;
    else if (mode == M_OUT)  cpu_rdata = outreg;
    else if (mode == M_BIT)  cpu_rdata = line;
    else                     cpu_rdata = inreg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= M_IN;
      seq     <= S_IDLE;
      stb_s   <= 2'b11;
      stb_q   <= 1'b1;
      din_s1  <= '0;
      din_s2  <= '0;
      outreg  <= '0;
      inreg   <= '0;
      dir     <= '1;
      mask    <= '1;
      vec     <= '0;
      rdy     <= 1'b0;
      ie      <= 1'b0;
      andm    <= 1'b0;
      lvl     <= 1'b0;
      pend    <= 1'b0;
      armed   <= 1'b0;
      match_q <= 1'b0;
    end else begin
      stb_s   <= {stb_s[0], per_stb_n};
      stb_q   <= stb_s[1];
      din_s1  <= per_din;
      din_s2  <= din_s1;
      match_q <= match;

      if (fall && (mode == M_BI || rdy)) begin
        armed <= 1'b1;
        if (mode == M_IN || (mode == M_BI && !rdy)) inreg <= din_s2;
        if (mode == M_IN) rdy <= 1'b0;
      end
      if (rise && armed) begin
        armed <= 1'b0;
        if (ie) pend <= 1'b1;
        if (mode != M_IN) rdy <= 1'b0;
      end
      if (match && !match_q && ie) pend <= 1'b1;

      if (dwr) begin
        outreg <= cpu_wdata;
        if (mode == M_OUT || mode == M_BI) rdy <= 1'b1;
      end
      if (drd && mode == M_IN) rdy <= 1'b1;

      if (cwr) begin
        case (seq)
          S_DIR: begin
            dir <= cpu_wdata;
            seq <= S_MASK;
          end
          S_MASK: begin
            mask <= cpu_wdata;
            seq  <= S_IDLE;
          end
          default: begin
            if (!cpu_wdata[0]) begin
              vec <= cpu_wdata;
            end else if (cpu_wdata[3:0] == 4'hF) begin
              mode  <= cpu_wdata[DW-1:DW-2];
              rdy   <= 1'b0;
              ie    <= 1'b0;
              pend  <= 1'b0;
              armed <= 1'b0;
              seq   <= (cpu_wdata[DW-1:DW-2] == M_BIT) ? S_DIR : S_IDLE;
            end else if (cpu_wdata[3:0] == 4'h7) begin
              ie   <= cpu_wdata[DW-1];
              andm <= cpu_wdata[DW-2];
              lvl  <= cpu_wdata[DW-3];
              if (!cpu_wdata[DW-1]) pend <= 1'b0;
            end else if (cpu_wdata[3:0] == 4'h3) begin
              ie <= cpu_wdata[DW-1];
              if (!cpu_wdata[DW-1]) pend <= 1'b0;
            end
          end
        endcase
      end

      if (irq_ack) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/hsport_chk.sv
module hsport_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_wr,
  input logic          out_load,
  input logic          per_rdy,
  input logic          irq,
  input logic          irq_ack,
  input logic [1:0]    mode,
  input logic [DW-1:0] inreg
);
  AST_MODE_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (!per_rdy && !irq)); // R3
  AST_LOAD_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_load && mode == 2'd0) |=> per_rdy); // R4
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq); // R11
  AST_INPUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && !per_rdy) |=> $stable(inreg)); // R6
  AST_BITMODE_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3) |-> !per_rdy); // R8
endmodule

bind hsport hsport_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode_wr  (cpu_wr && cpu_ctl && seq == 2'd0 && cpu_wdata[3:0] == 4'hF),
  .out_load (cpu_wr && !cpu_ctl),
  .per_rdy  (per_rdy),
  .irq      (irq),
  .irq_ack  (irq_ack),
  .mode     (mode),
  .inreg    (inreg)
);

// File: tb/sim_hsport.sv
module sim_hsport;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_wr = 0, cpu_rd = 0, cpu_ctl = 0, per_stb_n = 1, irq_ack = 0;
  logic [7:0] cpu_wdata = 0, per_din = 0;
  logic [7:0] cpu_rdata, per_dout, per_oe, vec;
  logic per_rdy, irq;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  hsport u0 (.clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_ctl(cpu_ctl),
             .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .per_din(per_din), .per_dout(per_dout),
             .per_oe(per_oe), .per_rdy(per_rdy), .per_stb_n(per_stb_n), .irq(irq),
             .irq_ack(irq_ack), .vec(vec));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic ctl, input logic [7:0] b);
    @(negedge clk); cpu_wr = 1; cpu_ctl = ctl; cpu_wdata = b;
    @(negedge clk); cpu_wr = 0; cpu_ctl = 0;
  endtask

  task automatic rd(output logic [7:0] b);
    @(negedge clk); cpu_rd = 1; cpu_ctl = 0; #1 b = cpu_rdata;
    @(negedge clk); cpu_rd = 0;
  endtask

  task automatic ack();
    @(negedge clk); irq_ack = 1;
    @(negedge clk); irq_ack = 0;
  endtask

  task automatic stb_low();  @(negedge clk); per_stb_n = 0; idle(5); endtask
  task automatic stb_high(); @(negedge clk); per_stb_n = 1; idle(5); endtask
  task automatic strobe();   stb_low(); stb_high(); endtask

  function automatic logic mt(input logic [7:0] v, input logic [7:0] m,
                              input logic a, input logic l);
    logic [7:0] h;
    h = l ? v : ~v;
    if (a) return (m != 8'hFF) && (&(h | m));
    return |(h & ~m);
  endfunction

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] a, b, r, d, m, o, v;
    logic am, lv, prev, now, exp_irq;
    void'($urandom(32'h5EED1234));
    idle(3); rst_n = 1; idle(1);
    chk("R1 rdy", {7'd0, per_rdy}, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 oe", per_oe, 8'h00);
    chk("R1 vec", vec, 8'h00);

    wr(1, 8'hA4); chk("R2 vec", vec, 8'hA4);
    for (int i = 0; i < 6; i++) begin
      a = 8'($urandom) & 8'hFE; wr(1, a); chk("R2 vec random", vec, a);
    end

    wr(1, 8'h0F); wr(1, 8'h83);
    chk("R3 rdy after mode", {7'd0, per_rdy}, 8'h00);
    chk("R4 oe", per_oe, 8'hFF);
    for (int i = 0; i < 6; i++) begin
      a = 8'($urandom); wr(0, a);
      chk("R4 dout", per_dout, a);
      chk("R4 rdy", {7'd0, per_rdy}, 8'h01);
      strobe();
      chk("R5 rdy drop", {7'd0, per_rdy}, 8'h00);
      chk("R5 irq", {7'd0, irq}, 8'h01);
      ack();
      chk("R11 ack", {7'd0, irq}, 8'h00);
    end
    strobe();
    chk("R5 idle strobe rdy", {7'd0, per_rdy}, 8'h00);
    chk("R5 idle strobe irq", {7'd0, irq}, 8'h00);
    wr(0, 8'h5A); wr(1, 8'h0F);
    chk("R3 mode clears rdy", {7'd0, per_rdy}, 8'h00);
    wr(0, 8'h66); strobe();
    chk("R3 ie cleared", {7'd0, irq}, 8'h00);
    wr(1, 8'h83); wr(1, 8'h03); wr(0, 8'h67); strobe();
    chk("R10 disabled", {7'd0, irq}, 8'h00);
    wr(1, 8'h83); ack();
    chk("R11 dropped event", {7'd0, irq}, 8'h00);

    wr(1, 8'h4F); wr(1, 8'h83);
    chk("R6 oe", per_oe, 8'h00);
    chk("R6 rdy after mode", {7'd0, per_rdy}, 8'h00);
    rd(r);
    chk("R6 rdy after read", {7'd0, per_rdy}, 8'h01);
    for (int i = 0; i < 4; i++) begin
      a = 8'($urandom); b = ~a;
      per_din = a; idle(2);
      stb_low();
      chk("R6 rdy in strobe", {7'd0, per_rdy}, 8'h00);
      per_din = b; stb_high();
      chk("R6 irq", {7'd0, irq}, 8'h01);
      ack();
      strobe();
      chk("R6 ignored irq", {7'd0, irq}, 8'h00);
      rd(r);
      chk("R6 data", r, a);
      chk("R6 rdy rearmed", {7'd0, per_rdy}, 8'h01);
    end

    wr(1, 8'h8F); wr(1, 8'h83);
    chk("R7 rdy", {7'd0, per_rdy}, 8'h00);
    chk("R7 oe idle", per_oe, 8'h00);
    a = 8'($urandom); per_din = a; idle(3);
    strobe();
    chk("R7 input irq", {7'd0, irq}, 8'h01);
    ack(); rd(r);
    chk("R7 input data", r, a);
    d = 8'($urandom); wr(0, d);
    chk("R7 rdy full", {7'd0, per_rdy}, 8'h01);
    chk("R7 oe stb high", per_oe, 8'h00);
    stb_low();
    chk("R7 oe stb low", per_oe, 8'hFF);
    chk("R7 dout", per_dout, d);
    stb_high();
    chk("R7 rdy empty", {7'd0, per_rdy}, 8'h00);
    chk("R7 oe after", per_oe, 8'h00);
    chk("R7 output irq", {7'd0, irq}, 8'h01);
    ack();

    wr(1, 8'h3C); a = vec;
    wr(1, 8'hCF); wr(1, 8'h10); wr(1, 8'hFE);
    chk("R8 seq not vector", vec, a);
    chk("R8 oe", per_oe, 8'hEF);
    chk("R8 rdy", {7'd0, per_rdy}, 8'h00);
    wr(1, 8'hCF); wr(1, 8'hFF); wr(1, 8'hFE); wr(1, 8'hA7);
    per_din = 8'h00; idle(5); ack();
    per_din = 8'hFE; idle(5);
    chk("R12 masked lines", {7'd0, irq}, 8'h00);
    per_din = 8'h7E; idle(5); per_din = 8'hFE; idle(5);
    chk("R12 masked toggle", {7'd0, irq}, 8'h00);
    per_din = 8'h01; idle(5);
    chk("R9 unmasked match", {7'd0, irq}, 8'h01);
    ack();

    for (int c = 0; c < 4; c++) begin
      d = 8'($urandom); m = 8'($urandom) & 8'h7F; o = 8'($urandom);
      am = 1'($urandom); lv = 1'($urandom);
      wr(1, 8'hCF); wr(1, d); wr(1, m); wr(0, o);
      chk("R8 oe random", per_oe, ~d);
      wr(1, {1'b1, am, lv, 5'b00111});
      per_din = 8'($urandom); idle(5); ack();
      v = (per_din & d) | (o & ~d);
      rd(r);
      chk("R8 read mix", r, v);
      prev = mt(v, m, am, lv); exp_irq = 0;
      for (int s = 0; s < 16; s++) begin
        per_din = (s % 4 == 3) ? (am ? (lv ? 8'hFF : 8'h00) : (lv ? 8'hFF : 8'h00)) : 8'($urandom);
        idle(5);
        v = (per_din & d) | (o & ~d);
        now = mt(v, m, am, lv);
        exp_irq = exp_irq | (now & ~prev);
        prev = now;
        chk("R9 random match", {7'd0, irq}, {7'd0, exp_irq});
        if (irq) begin ack(); exp_irq = 0; end
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule